// File: doc/BRIEF.md
# Prescaled Timer/Counter with 8/16-bit Wrap

This block is a free-running counter with a small register interface. It advances on one of two sources. The first is a single-cycle enable at instruction rate. The second is an edge on an external pin, and software picks whether a rising or a falling edge counts. A power-of-two prescaler can sit between the source and the counter, or software can take it out of the path entirely. One mode bit sets how far the counter runs before it wraps: the low byte only, or the full two bytes.

Software sets the block up by writing a single control byte. It can load or read either counter byte at any time. When the counter wraps, the block raises a sticky overflow flag, and the `irq` output carries that flag to an interrupt controller outside the block. Software clears the flag by writing a zero to it.

Top module: `ptc_timer`

## Requirements
- R1: After reset the control byte, both counter bytes and the overflow flag read as zero, and `irq` is low.
- R2: While control bit 0 (run) is 0, the counter holds its value whatever the sources do.
- R3: With run=1, control bit 2 (external select) = 0 and control bit 4 (prescaler bypass) = 1, the counter advances once for each clock cycle in which `tick_en` is high.
- R4: With control bit 4 = 0, the counter advances once per 2^(k+1) source events, where k is the value of control bits 7:5 (0 gives 1:2, 7 gives 1:256).
- R5: With control bit 2 = 1 and control bit 3 (falling select) = 0, each low-to-high transition of `ext_pin` advances the counter exactly once, and `tick_en` has no effect.
- R6: With control bit 3 = 1, only high-to-low transitions of `ext_pin` advance the counter, and rising transitions are ignored.
- R7: With control bit 1 (byte mode) = 1, the low byte wraps from 0xFF to 0x00 and sets the overflow flag, and the high byte is unchanged.
- R8: With control bit 1 = 0, the counter wraps from 0xFFFF to 0x0000 and sets the flag. A carry from 0x00FF to 0x0100 does not set the flag.
- R9: The overflow flag (bit 0 at address 3) stays set until bit 0 of a write to address 3 is 0. A write of 1 leaves it unchanged. `irq` always equals the flag.
- R10: A write to either counter byte clears the prescaler's partial count but leaves the ratio unchanged.
- R11: Register addresses: 0 holds the control byte, 1 the counter low byte, 2 the counter high byte and 3 the flag. Reads return the current contents at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Instruction-rate count enable, one cycle per event |
| ext_pin | input | 1 | External count input, asynchronous |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, valid with bus_sel |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| irq | output | 1 | Overflow interrupt request, equals the flag |

## Verification
The wrap and carry properties assume that a counter write in the same cycle as an increment takes priority, so each property excludes the cycles that contain a counter write. The stimulus holds `ext_pin` at each level for several cycles, longer than the synchroniser's latency, so no edge is lost or merged. All reads take place while the sources are quiet, so the value read is stable across the sampling point.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
   localparam int unsigned REG_W = 8;
   localparam int unsigned ADDR_W = 2;

   typedef enum logic [ADDR_W-1:0] {
      RA_CTRL = 2'd0,
      RA_CLO  = 2'd1,
      RA_CHI  = 2'd2,
      RA_FLAG = 2'd3
   } ptc_addr_e;

   // control byte, msb first
   typedef struct packed {
      logic [2:0] ratio;   // 7:5 prescale select
      logic       bypass;  // 4
      logic       fall;    // 3
      logic       ext;     // 2
      logic       narrow;  // 1
      logic       run;     // 0
   } ptc_ctrl_t;
endpackage

// File: rtl/ptc_edge.sv
module ptc_edge #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic fall,
   output logic pulse
);
   if (STAGES < 2) begin : g_bad_stages
      $error("ptc_edge: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sync_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[0] <= 1'b0;
      else        sync_q[0] <= pin;
   end

   for (genvar g = 1; g < STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q[g] <= 1'b0;
         else        sync_q[g] <= sync_q[g-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sync_q[STAGES-1];
   end

   always_comb begin
      if (fall) pulse = prev_q & ~sync_q[STAGES-1];
      else      pulse = ~prev_q & sync_q[STAGES-1];
   end
endmodule

// File: rtl/ptc_prescale.sv
module ptc_prescale #(
   parameter int unsigned PS_W  = 8,
   parameter int unsigned SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             src,
   input  logic             bypass,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam int unsigned SH_W = SEL_W + 1;

   if (PS_W != (1 << SEL_W)) begin : g_bad_width
      $error("ptc_prescale: PS_W must equal 2**SEL_W");
   end

   logic [PS_W-1:0] psc_q;
   logic [PS_W-1:0] mask;
   logic [SH_W-1:0] shamt;

   always_comb begin
      shamt = {1'b0, sel} + SH_W'(1);
      mask  = ~({PS_W{1'b1}} << shamt);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              psc_q <= '0;
      else if (clr)            psc_q <= '0;
      else if (src && !bypass) psc_q <= psc_q + PS_W'(1);
   end

   always_comb begin
      if (bypass) tick = src;
      else        tick = src && ((psc_q & mask) == mask);
   end
endmodule

// File: rtl/ptc_count.sv
module ptc_count #(
   parameter int unsigned BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inc,
   input  logic              narrow,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [BYTE_W-1:0] wdata,
   output logic [2*BYTE_W-1:0] cnt,
   output logic              wrap
);
   localparam int unsigned W = 2 * BYTE_W;

   logic [BYTE_W-1:0] lo_q, hi_q;
   logic              any_wr;

   assign any_wr = wr_lo | wr_hi;
   assign cnt    = {hi_q, lo_q};
   assign wrap   = inc && !any_wr && (narrow ? (&lo_q) : (&cnt));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= '0;
      end else if (any_wr) begin
         if (wr_lo) lo_q <= wdata;
         if (wr_hi) hi_q <= wdata;
      end else if (inc) begin
         if (narrow) begin
            lo_q <= lo_q + BYTE_W'(1);
         end else begin
            {hi_q, lo_q} <= cnt + W'(1);
         end
      end
   end
endmodule

// File: rtl/ptc_timer.sv
module ptc_timer
   import ptc_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned PS_W        = 8,
   parameter int unsigned SEL_W       = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             ext_pin,
   input  logic             bus_sel,
   input  logic             bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [REG_W-1:0] bus_wdata,
   output logic [REG_W-1:0] bus_rdata,
   output logic             irq
);
   localparam int unsigned CNT_W = 2 * REG_W;

   if (SEL_W != 3) begin : g_bad_sel
      $error("ptc_timer: control byte holds a 3-bit ratio field");
   end

   ptc_ctrl_t        ctrl_q;
   logic             flag_q;
   logic             wr_ctrl, wr_lo, wr_hi, wr_flag;
   logic             cnt_wr, flag_clr;
   logic             ext_pulse, src, inc, wrap;
   logic [CNT_W-1:0] cnt;

   always_comb begin
      wr_ctrl = bus_sel && bus_wr && (bus_addr == RA_CTRL);
      wr_lo   = bus_sel && bus_wr && (bus_addr == RA_CLO);
      wr_hi   = bus_sel && bus_wr && (bus_addr == RA_CHI);
      wr_flag = bus_sel && bus_wr && (bus_addr == RA_FLAG);
   end

   assign cnt_wr   = wr_lo | wr_hi;
   assign flag_clr = wr_flag && !bus_wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (wr_ctrl) ctrl_q <= ptc_ctrl_t'(bus_wdata);
   end

   ptc_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .pin   (ext_pin),
      .fall  (ctrl_q.fall),
      .pulse (ext_pulse)
   );

   assign src = ctrl_q.run && (ctrl_q.ext ? ext_pulse : tick_en);

   ptc_prescale #(.PS_W(PS_W), .SEL_W(SEL_W)) u_psc (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (cnt_wr),
      .src    (src),
      .bypass (ctrl_q.bypass),
      .sel    (ctrl_q.ratio),
      .tick   (inc)
   );

   ptc_count #(.BYTE_W(REG_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .inc    (inc),
      .narrow (ctrl_q.narrow),
      .wr_lo  (wr_lo),
      .wr_hi  (wr_hi),
      .wdata  (bus_wdata),
      .cnt    (cnt),
      .wrap   (wrap)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_q <= 1'b0;
      else if (wrap)     flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
   end

   assign irq = flag_q;

   always_comb begin
      unique case (bus_addr)
         RA_CTRL: bus_rdata = ctrl_q;
         RA_CLO:  bus_rdata = cnt[REG_W-1:0];
         RA_CHI:  bus_rdata = cnt[CNT_W-1:REG_W];
         default: bus_rdata = {{(REG_W-1){1'b0}}, flag_q};
      endcase
   end
endmodule

// File: rtl/ptc_timer_chk.sv
module ptc_timer_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        run,
   input logic        narrow,
   input logic        inc,
   input logic        cnt_wr,
   input logic        flag_clr,
   input logic        flag,
   input logic [15:0] cnt
);
   assert_halt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !cnt_wr) |=> $stable(cnt));

   assert_halt_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !inc);

   assert_byte_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (narrow && inc && !cnt_wr && cnt[7:0] == 8'hFF)
      |=> (cnt[7:0] == 8'h00 && flag && cnt[15:8] == $past(cnt[15:8])));

   assert_word_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!narrow && inc && !cnt_wr && cnt == 16'hFFFF) |=> (cnt == 16'h0000 && flag));

   assert_carry_no_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!narrow && inc && !cnt_wr && !flag && cnt[7:0] == 8'hFF && cnt[15:8] != 8'hFF)
      |=> (!flag && cnt[15:8] == 8'($past(cnt[15:8]) + 8'd1)));

   assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !flag_clr) |=> flag);
endmodule

bind ptc_timer ptc_timer_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .run      (ctrl_q.run),
   .narrow   (ctrl_q.narrow),
   .inc      (inc),
   .cnt_wr   (cnt_wr),
   .flag_clr (flag_clr),
   .flag     (flag_q),
   .cnt      (cnt)
);

// File: tb/ptc_timer_tb.sv
module ptc_timer_tb;
   localparam int CLK_PER = 10;
   localparam int WD_CYC  = 200000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic       ext_pin = 1'b0;
   logic       bus_sel = 1'b0;
   logic       bus_wr = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'd0;
   logic [7:0] bus_rdata;
   logic       irq;
   logic       rd_req = 1'b0;

   int n_run = 0;
   int n_fail = 0;

   typedef struct {
      logic [7:0] exp;
      string      tag;
   } sb_item_t;
   sb_item_t sb_q[$];
   sb_item_t cur;

   always #(CLK_PER/2) clk = ~clk;

   ptc_timer u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_en   (tick_en),
      .ext_pin   (ext_pin),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq       (irq)
   );

   // monitor: pops expected items as reads complete
   always @(posedge clk) begin
      if (rd_req) begin
         #(CLK_PER/4);
         cur = sb_q.pop_front();
         n_run++;
         if (bus_rdata !== cur.exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", cur.tag, bus_rdata, cur.exp);
         end
      end
   end

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic exp_rd(input logic [1:0] a, input logic [7:0] e, input string tag);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      sb_q.push_back('{exp: e, tag: tag});
      rd_req = 1'b1;
      @(negedge clk);
      rd_req = 1'b0; bus_sel = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) tick_en = 1'b1;
         @(negedge clk) tick_en = 1'b0;
      end
   endtask

   task automatic pin_set(input logic v);
      @(negedge clk) ext_pin = v;
      repeat (5) @(negedge clk);
   endtask

   task automatic chk_irq(input logic e, input string tag);
      @(negedge clk);
      n_run++;
      if (irq !== e) begin
         n_fail++;
         $display("FAIL %s: irq got %0b expected %0b", tag, irq, e);
      end
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      repeat (WD_CYC) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      exp_rd(2'd0, 8'h00, "R1 ctrl");
      exp_rd(2'd1, 8'h00, "R1 lo");
      exp_rd(2'd2, 8'h00, "R1 hi");
      exp_rd(2'd3, 8'h00, "R1 flag");
      chk_irq(1'b0, "R1 irq");

      // R2 halted
      wr(2'd0, 8'h10);
      ticks(5);
      exp_rd(2'd1, 8'h00, "R2 halted");

      // R3 internal, bypass
      wr(2'd0, 8'h11);
      ticks(5);
      exp_rd(2'd1, 8'h05, "R3 internal count");

      // R4 ratios
      wr(2'd0, 8'h01);
      wr(2'd1, 8'h00);
      ticks(7);
      exp_rd(2'd1, 8'h03, "R4 ratio 1:2");
      wr(2'd0, 8'h41);
      wr(2'd1, 8'h00);
      ticks(17);
      exp_rd(2'd1, 8'h02, "R4 ratio 1:8");
      wr(2'd0, 8'hE1);
      wr(2'd1, 8'h00);
      ticks(255);
      exp_rd(2'd1, 8'h00, "R4 ratio 1:256 before");
      ticks(1);
      exp_rd(2'd1, 8'h01, "R4 ratio 1:256 at");

      // R10 counter write clears prescaler
      wr(2'd0, 8'h21);
      wr(2'd1, 8'h00);
      ticks(3);
      exp_rd(2'd1, 8'h00, "R10 partial");
      wr(2'd1, 8'h10);
      ticks(3);
      exp_rd(2'd1, 8'h10, "R10 cleared");
      ticks(1);
      exp_rd(2'd1, 8'h11, "R10 ratio kept");

      // R5 external rising
      wr(2'd0, 8'h15);
      wr(2'd1, 8'h00);
      ticks(4);
      for (int i = 0; i < 3; i++) begin
         pin_set(1'b1);
         pin_set(1'b0);
      end
      exp_rd(2'd1, 8'h03, "R5 rising edges");

      // R6 external falling
      wr(2'd0, 8'h1D);
      wr(2'd1, 8'h00);
      for (int i = 0; i < 2; i++) begin
         pin_set(1'b1);
         pin_set(1'b0);
      end
      exp_rd(2'd1, 8'h02, "R6 falling edges");
      pin_set(1'b1);
      exp_rd(2'd1, 8'h02, "R6 rise ignored");
      pin_set(1'b0);
      exp_rd(2'd1, 8'h03, "R6 fall counted");

      // R7 byte wrap
      wr(2'd0, 8'h13);
      wr(2'd2, 8'h12);
      wr(2'd1, 8'hFE);
      ticks(1);
      exp_rd(2'd1, 8'hFF, "R7 before wrap");
      exp_rd(2'd3, 8'h00, "R7 flag before");
      ticks(1);
      exp_rd(2'd1, 8'h00, "R7 wrapped lo");
      exp_rd(2'd2, 8'h12, "R7 hi unchanged");
      exp_rd(2'd3, 8'h01, "R7 flag set");
      chk_irq(1'b1, "R7 irq");

      // R9 sticky flag
      wr(2'd3, 8'h01);
      exp_rd(2'd3, 8'h01, "R9 write one keeps");
      wr(2'd3, 8'h00);
      exp_rd(2'd3, 8'h00, "R9 write zero clears");
      chk_irq(1'b0, "R9 irq cleared");

      // R8 word mode
      wr(2'd0, 8'h11);
      wr(2'd2, 8'h00);
      wr(2'd1, 8'hFF);
      ticks(1);
      exp_rd(2'd1, 8'h00, "R8 carry lo");
      exp_rd(2'd2, 8'h01, "R8 carry hi");
      exp_rd(2'd3, 8'h00, "R8 carry no flag");
      wr(2'd2, 8'hFF);
      wr(2'd1, 8'hFF);
      ticks(1);
      exp_rd(2'd1, 8'h00, "R8 wrap lo");
      exp_rd(2'd2, 8'h00, "R8 wrap hi");
      exp_rd(2'd3, 8'h01, "R8 wrap flag");
      wr(2'd3, 8'h00);

      // R11 readback
      wr(2'd0, 8'hA5);
      exp_rd(2'd0, 8'hA5, "R11 ctrl readback");

      wait (sb_q.size() == 0);
      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule